// File: doc/BRIEF.md
# Multi-Rate Quasi-Cyclic LDPC Encoder

This block is a bit-serial systematic encoder for a quasi-cyclic LDPC code family with three code rates and three block lengths. It takes one information bit per cycle, framed by start, end and valid strobes. The code rate and block length are chosen for each frame through two 2-bit index inputs, which are sampled on the accepted start bit. The information bits leave unchanged one cycle after they enter. When the last information bit of the frame has been taken, the stored parity bits follow, one per cycle, with no gap.

The parity bits are built in a bank of parallel units, each holding one circulant of M parity bits. A row counter, derived from the bit count, selects a generator row of M-by-Nc entries from a table that is computed in logic. The row in use is rotated by one position after every information bit, and each unit XORs its circulant with the rotated entries whenever the information bit is 1. For verification the sizes are scaled down while the structure is kept: every configuration has 8 row groups, M grows by a factor of 4 per length step (so the lengths keep the 1:4:16 ratio of 1024, 4096 and 16384 bits), and Nc sets the rate.

The block is ready for a new frame only when it is idle. A valid start that arrives while a frame is still in progress drops that frame and begins the new one on the same bit.

Top module: `ar4ja_ldpc_enc`

## Requirements
- R1: The rate index selects the number of parity units Nc. Index 0 (rate 1/2) gives Nc = 8, index 1 (rate 2/3) gives Nc = 4, and index 2 (rate 4/5) gives Nc = 2. The parity length is P = Nc*M.
- R2: The length index selects the circulant size M = 2*4^idx, which is 2, 8 or 32. The information length is K = 8*M, which is 16, 64 or 256.
- R3: Parity bit (u, p), with unit u < Nc and position p < M, is the XOR over all information bits i of d_i AND g(i div M, u, (p - i mod M) mod M). Here g(r, u, q) = 1 exactly when (3r + 5u + 7q + r*u*q) mod 4 = 1.
- R4: Each accepted information bit appears on out_data with out_valid exactly one cycle later, and out_start is set on the first of them. After the K-th bit, the P parity bits follow on consecutive cycles, ordered by unit ascending and then by position ascending, with out_end set on the last one.
- R5: After reset, ready is 1 and out_valid is 0. From an accepted start until the cycle after the last parity bit has been sent, ready is 0.
- R6: A valid start with legal indices that arrives while a frame is in progress drops that frame. None of its unsent parity bits is output, and the new frame begins with that bit. This holds even in the cycle in which the final parity bit would have left.
- R7: A start that carries index value 3 in either index input is rejected. No bit is taken, nothing is output, ready stays 1 when idle, and a frame already in progress continues unaffected.
- R8: The indices are latched on the accepted start. Changes to them during the rest of the frame have no effect.
- R9: Cycles with in_valid low during the information phase take no bit and produce no output. The frame resumes on the next valid bit.
- R10: If in_end arrives on any bit other than the K-th, that bit is still passed through, but the frame is dropped with no parity output and ready returns to 1 in the next cycle.
- R11: Every frame starts its parity from zero, so an all-zero frame gives all-zero parity even after a frame with nonzero parity.
- R12: Valid bits without a start are ignored while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit qualifier |
| in_start | input | 1 | First bit of an input frame |
| in_end | input | 1 | Last bit of an input frame |
| in_data | input | 1 | Information bit |
| rate_idx | input | 2 | Code-rate selector, sampled on start |
| len_idx | input | 2 | Block-length selector, sampled on start |
| out_valid | output | 1 | Output bit qualifier |
| out_start | output | 1 | First bit of an output codeword |
| out_end | output | 1 | Last bit of an output codeword |
| out_data | output | 1 | Codeword bit |
| ready | output | 1 | Idle and able to accept a new frame |

## Verification
The parity readout and the acceptance of a new frame can fall in the same cycle. The bench provokes this by placing a legal start exactly on the cycle in which the final parity bit of the previous codeword would leave, and also on an earlier parity cycle and in the middle of an information phase. The behavioural model then expects the first bit of the new frame, marked with out_start, in place of the parity bit. It expects that no out_end appears for the dropped codeword, and it expects the new frame's parity to be free of any residue from the old one. A second collision, a reserved-index start arriving in the middle of a frame, is judged by the old frame finishing bit-exactly.

// File: rtl/ar4ja_enc_pkg.sv
package ar4ja_enc_pkg;

    // Scaled geometry: every configuration has ROWS row groups.
    parameter int ROWS         = 8;
    parameter int M_MIN_LOG    = 1;   // log2 of circulant size at length index 0
    parameter int LEN_STEP_LOG = 2;   // log2 of growth per length step

    localparam int ROW_W     = $clog2(ROWS);
    localparam int NC_MAX    = ROWS;
    localparam int NC_W      = $clog2(NC_MAX + 1);
    localparam int M_MAX_LOG = M_MIN_LOG + 2 * LEN_STEP_LOG;
    localparam int M_MAX     = 1 << M_MAX_LOG;
    localparam int MLOG_W    = $clog2(M_MAX_LOG + 3);
    localparam int K_MAX     = ROWS * M_MAX;
    localparam int CNT_W     = $clog2(K_MAX);
    localparam int PAR_BITS  = NC_MAX * M_MAX;
    localparam int PIDX_W    = $clog2(PAR_BITS);

    // Parity memory image: one circulant per unit.
    typedef logic [NC_MAX-1:0][M_MAX-1:0] pblock_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INFO = 2'd1,
        ST_PAR  = 2'd2
    } enc_state_t;

    typedef struct packed {
        logic [MLOG_W-1:0] m_log;
        logic [NC_W-1:0]   nc;
        logic [CNT_W-1:0]  k_last;
        logic [PIDX_W-1:0] p_last;
    } enc_cfg_t;

    // Scaled generator entry for row group r, unit u, circulant position q.
    function automatic logic gen_entry(int r, int u, int q);
        return ((3 * r + 5 * u + 7 * q + r * u * q) % 4) == 1;
    endfunction

    // Generator row for the active configuration; unused units and positions zero.
    function automatic pblock_t gen_row(logic [ROW_W-1:0] row,
                                        logic [NC_W-1:0] nc,
                                        logic [MLOG_W-1:0] m_log);
        pblock_t g;
        g = '0;
        for (int u = 0; u < NC_MAX; u++) begin
            for (int q = 0; q < M_MAX; q++) begin
                if (u < int'(nc) && q < (1 << int'(m_log)))
                    g[u][q] = gen_entry(int'(row), u, q);
            end
        end
        return g;
    endfunction

    // Circular shift by one inside the active M positions of every unit.
    function automatic pblock_t rotate_units(pblock_t x, logic [MLOG_W-1:0] m_log);
        pblock_t y;
        int m;
        m = 1 << int'(m_log);
        y = '0;
        for (int u = 0; u < NC_MAX; u++) begin
            for (int q = 0; q < M_MAX; q++) begin
                if (q < m && m <= M_MAX)
                    y[u][q] = (q == 0) ? x[u][m-1] : x[u][q-1];
            end
        end
        return y;
    endfunction

endpackage

// File: rtl/ar4ja_cfg_dec.sv
module ar4ja_cfg_dec
    import ar4ja_enc_pkg::*;
(
    input  logic [1:0] rate_idx,
    input  logic [1:0] len_idx,
    output enc_cfg_t   cfg,
    output logic       cfg_ok
);
    int m_log_i;
    int nc_i;

    always_comb begin
        m_log_i    = M_MIN_LOG + LEN_STEP_LOG * int'(len_idx);
        nc_i       = NC_MAX >> int'(rate_idx);
        cfg.m_log  = MLOG_W'(m_log_i);
        cfg.nc     = NC_W'(nc_i);
        cfg.k_last = CNT_W'((ROWS << m_log_i) - 1);
        cfg.p_last = PIDX_W'((nc_i << m_log_i) - 1);
        cfg_ok     = (rate_idx != 2'd3) && (len_idx != 2'd3);
    end
endmodule

// File: rtl/ar4ja_gen_rom.sv
module ar4ja_gen_rom
    import ar4ja_enc_pkg::*;
(
    input  logic [ROW_W-1:0]  row,
    input  logic [NC_W-1:0]   nc,
    input  logic [MLOG_W-1:0] m_log,
    output pblock_t           row_bits
);
    always_comb row_bits = gen_row(row, nc, m_log);
endmodule

// File: rtl/ar4ja_par_acc.sv
module ar4ja_par_acc
    import ar4ja_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              frame_first,
    input  logic              grp_first,
    input  pblock_t           row_bits,
    input  logic [MLOG_W-1:0] m_log,
    output pblock_t           parity
);
    pblock_t gen_q;
    pblock_t gen_cur;
    pblock_t par_q;
    pblock_t par_nxt;

    // A new row group reloads the table row; otherwise use the rotated copy.
    always_comb gen_cur = grp_first ? row_bits : gen_q;

    for (genvar u = 0; u < NC_MAX; u++) begin : g_unit
        assign par_nxt[u] = (frame_first ? {M_MAX{1'b0}} : par_q[u])
                          ^ (bit_in ? gen_cur[u] : {M_MAX{1'b0}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
            par_q <= '0;
        end else if (bit_en) begin
            gen_q <= rotate_units(gen_cur, m_log);
            par_q <= par_nxt;
        end
    end

    assign parity = par_q;
endmodule

// File: rtl/ar4ja_par_rd.sv
module ar4ja_par_rd
    import ar4ja_enc_pkg::*;
(
    input  pblock_t           parity,
    input  logic [PIDX_W-1:0] rd_idx,
    input  logic [MLOG_W-1:0] m_log,
    output logic              par_bit
);
    int uu;
    int pp;

    always_comb begin
        uu = int'(rd_idx) >> int'(m_log);
        pp = int'(rd_idx) & ((1 << int'(m_log)) - 1);
        par_bit = 1'b0;
        if (uu < NC_MAX && pp < M_MAX)
            par_bit = parity[uu][pp];
    end
endmodule

// File: rtl/ar4ja_ldpc_enc.sv
module ar4ja_ldpc_enc
    import ar4ja_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       in_end,
    input  logic       in_data,
    input  logic [1:0] rate_idx,
    input  logic [1:0] len_idx,
    output logic       out_valid,
    output logic       out_start,
    output logic       out_end,
    output logic       out_data,
    output logic       ready
);
    enc_state_t        state_q;
    enc_cfg_t          cfg_q;
    enc_cfg_t          dec_cfg;
    enc_cfg_t          cfg_act;
    logic              dec_ok;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic [CNT_W-1:0]  grp_mask;
    logic [PIDX_W-1:0] rd_q;
    logic [ROW_W-1:0]  row;
    logic              start_acc;
    logic              bit_take;
    logic              last_bit;
    logic              grp_first;
    logic              par_bit;
    pblock_t           row_bits;
    pblock_t           parity;

    ar4ja_cfg_dec u_dec (
        .rate_idx (rate_idx),
        .len_idx  (len_idx),
        .cfg      (dec_cfg),
        .cfg_ok   (dec_ok)
    );

    // Accepted start takes priority over every state.
    always_comb begin
        start_acc = in_valid & in_start & dec_ok;
        bit_take  = start_acc | (in_valid & ~in_start & (state_q == ST_INFO));
        cfg_act   = start_acc ? dec_cfg : cfg_q;
        cnt_eff   = start_acc ? '0 : cnt_q;
        grp_mask  = CNT_W'((1 << int'(cfg_act.m_log)) - 1);
        grp_first = (cnt_eff & grp_mask) == '0;
        row       = ROW_W'(cnt_eff >> cfg_act.m_log);
        last_bit  = (cnt_eff == cfg_act.k_last);
    end

    ar4ja_gen_rom u_rom (
        .row      (row),
        .nc       (cfg_act.nc),
        .m_log    (cfg_act.m_log),
        .row_bits (row_bits)
    );

    ar4ja_par_acc u_acc (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_take),
        .bit_in      (in_data),
        .frame_first (start_acc),
        .grp_first   (grp_first),
        .row_bits    (row_bits),
        .m_log       (cfg_act.m_log),
        .parity      (parity)
    );

    ar4ja_par_rd u_rd (
        .parity  (parity),
        .rd_idx  (rd_q),
        .m_log   (cfg_q.m_log),
        .par_bit (par_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            cnt_q     <= '0;
            rd_q      <= '0;
            out_valid <= 1'b0;
            out_start <= 1'b0;
            out_end   <= 1'b0;
            out_data  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_start <= 1'b0;
            out_end   <= 1'b0;
            out_data  <= 1'b0;
            if (start_acc)
                cfg_q <= dec_cfg;
            if (bit_take) begin
                out_valid <= 1'b1;
                out_data  <= in_data;
                out_start <= (cnt_eff == '0);
                if (in_end && !last_bit) begin
                    state_q <= ST_IDLE;
                end else if (last_bit) begin
                    state_q <= ST_PAR;
                    rd_q    <= '0;
                end else begin
                    state_q <= ST_INFO;
                    cnt_q   <= cnt_eff + 1'b1;
                end
            end else if (state_q == ST_PAR) begin
                out_valid <= 1'b1;
                out_data  <= par_bit;
                out_end   <= (rd_q == cfg_q.p_last);
                if (rd_q == cfg_q.p_last)
                    state_q <= ST_IDLE;
                else
                    rd_q <= rd_q + 1'b1;
            end
        end
    end

    assign ready = (state_q == ST_IDLE);
endmodule

// File: rtl/ar4ja_ldpc_chk.sv
module ar4ja_ldpc_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_start,
    input logic       in_end,
    input logic [1:0] rate_idx,
    input logic [1:0] len_idx,
    input logic       out_valid,
    input logic       out_start,
    input logic       out_end,
    input logic       ready
);
    logic legal_start;
    logic bad_start;
    assign legal_start = in_valid && in_start && rate_idx != 2'd3 && len_idx != 2'd3;
    assign bad_start   = in_valid && in_start && (rate_idx == 2'd3 || len_idx == 2'd3);

    assert_start_out_R4: assert property (@(posedge clk) disable iff (rst)
        (legal_start && !in_end) |=> (out_valid && out_start && !ready));

    assert_reject_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (ready && bad_start) |=> (ready && !out_valid));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (ready && !(in_valid && in_start)) |=> (ready && !out_valid));

    assert_end_frees_R5: assert property (@(posedge clk) disable iff (rst)
        out_end |-> (out_valid && ready && !out_start));

    assert_known_R5: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({out_valid, ready}));
endmodule

bind ar4ja_ldpc_enc ar4ja_ldpc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_end    (in_end),
    .rate_idx  (rate_idx),
    .len_idx   (len_idx),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_end   (out_end),
    .ready     (ready)
);

// File: tb/tb_ar4ja_ldpc_enc.sv
`timescale 1ns/1ps
module tb_ar4ja_ldpc_enc;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0, in_data = 1'b0;
    logic [1:0] rate_idx = 2'd0, len_idx = 2'd0;
    logic out_valid, out_start, out_end, out_data, ready;

    always #2 clk = ~clk;

    ar4ja_ldpc_enc dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_end(in_end), .in_data(in_data), .rate_idx(rate_idx),
        .len_idx(len_idx), .out_valid(out_valid), .out_start(out_start),
        .out_end(out_end), .out_data(out_data), .ready(ready)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R5";
    bit done = 0;

    typedef struct { bit d; bit s; bit e; } item_t;
    item_t q[$];
    bit m_active = 0;
    int m_cnt, m_M, m_K, m_nc, m_P;
    bit m_par[256];
    logic [15:0] lfsr = 16'hACE1;

    function automatic bit g_ref(int r, int u, int p);
        return ((3 * r + 5 * u + 7 * p + r * u * p) % 4) == 1;
    endfunction

    function automatic bit next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        item_t it;
        if (q.size() > 0) begin
            it = q.pop_front();
            check(out_valid === 1'b1, "out_valid", int'(out_valid), 1);
            check(out_data === it.d, "out_data", int'(out_data), int'(it.d));
            check(out_start === it.s, "out_start", int'(out_start), int'(it.s));
            check(out_end === it.e, "out_end", int'(out_end), int'(it.e));
        end else begin
            check(out_valid === 1'b0, "out_valid idle", int'(out_valid), 0);
        end
        check(ready === (!m_active && q.size() == 0), "ready", int'(ready),
              int'(!m_active && q.size() == 0));
    endtask

    task automatic model_bit(bit d, bit e);
        int r, t;
        item_t it;
        it.d = d; it.s = (m_cnt == 0); it.e = 0;
        q.push_back(it);
        r = m_cnt / m_M;
        t = m_cnt % m_M;
        if (d) begin
            for (int u = 0; u < m_nc; u++)
                for (int p = 0; p < m_M; p++)
                    if (g_ref(r, u, (p - t + m_M) % m_M))
                        m_par[u * m_M + p] ^= 1'b1;
        end
        if (e && m_cnt != m_K - 1) begin
            m_active = 0;
        end else if (m_cnt == m_K - 1) begin
            for (int i = 0; i < m_P; i++) begin
                it.d = m_par[i]; it.s = 0; it.e = (i == m_P - 1);
                q.push_back(it);
            end
            m_active = 0;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic drive(bit v, bit s, bit e, bit d, logic [1:0] ri, logic [1:0] li);
        @(negedge clk);
        compare();
        in_valid = v; in_start = s; in_end = e; in_data = d;
        rate_idx = ri; len_idx = li;
        if (v && s) begin
            if (ri != 2'd3 && li != 2'd3) begin
                q.delete();
                m_M  = 2 << (2 * int'(li));
                m_K  = 8 * m_M;
                m_nc = 8 >> int'(ri);
                m_P  = m_nc * m_M;
                for (int i = 0; i < 256; i++) m_par[i] = 0;
                m_cnt = 0;
                m_active = 1;
                model_bit(d, e);
            end
        end else if (v && m_active) begin
            model_bit(d, e);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 2'd0, 2'd0);
    endtask

    task automatic drain();
        int guard = 0;
        while ((m_active || q.size() > 0) && guard < 2000) begin
            drive(0, 0, 0, 0, 2'd0, 2'd0);
            guard++;
        end
        idle(1);
    endtask

    // mode 0 pseudo-random data, 1 all zero, 2 indices altered after start
    task automatic send(logic [1:0] ri, logic [1:0] li, int mode, int gap,
                        int nbits, int rsv_at, int end_at);
        int k, n;
        bit d, e;
        logic [1:0] rr, ll;
        k = 16 << (2 * int'(li));
        n = (nbits < 0) ? k : nbits;
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && i % gap == 1) drive(0, 0, 0, 1, ri, li);
            if (i == rsv_at) drive(1, 1, 0, 1, 2'd3, li);
            d  = (mode == 1) ? 1'b0 : next_bit();
            e  = (end_at < 0) ? (i == k - 1) : (i == end_at);
            rr = (mode == 2 && i > 0) ? 2'((int'(ri) + 1) % 3) : ri;
            ll = (mode == 2 && i > 0) ? 2'((int'(li) + 1) % 3) : li;
            drive(1, (i == 0), e, d, rr, ll);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        cur_req = "R5";            // reset state
        idle(2);

        cur_req = "R12";           // valid bits with no start while idle
        for (int i = 0; i < 5; i++) drive(1, 0, i == 4, 1, 2'd0, 2'd0);
        idle(1);

        cur_req = "R1 R2 R3 R4";   // each rate and length
        send(2'd0, 2'd0, 0, 0, -1, -1, -1); drain();
        send(2'd1, 2'd0, 0, 0, -1, -1, -1); drain();
        send(2'd2, 2'd0, 0, 0, -1, -1, -1); drain();
        send(2'd0, 2'd1, 0, 0, -1, -1, -1); drain();
        send(2'd2, 2'd1, 0, 0, -1, -1, -1); drain();
        send(2'd1, 2'd2, 0, 0, -1, -1, -1); drain();
        send(2'd0, 2'd2, 0, 0, -1, -1, -1); drain();

        cur_req = "R9";            // gaps in the information phase
        send(2'd1, 2'd1, 0, 3, -1, -1, -1); drain();

        cur_req = "R8";            // indices changed mid-frame
        send(2'd0, 2'd1, 2, 0, -1, -1, -1); drain();

        cur_req = "R11";           // zero frame after nonzero frame
        send(2'd0, 2'd0, 0, 0, -1, -1, -1); drain();
        send(2'd0, 2'd0, 1, 0, -1, -1, -1); drain();

        cur_req = "R6";            // abort mid information phase
        send(2'd0, 2'd0, 0, 0, 7, -1, -1);
        send(2'd2, 2'd0, 0, 0, -1, -1, -1); drain();
        cur_req = "R6";            // abort mid parity readout
        send(2'd0, 2'd0, 0, 0, -1, -1, -1);
        idle(3);
        send(2'd1, 2'd0, 0, 0, -1, -1, -1); drain();
        cur_req = "R6";            // abort on the final parity cycle (P = 4)
        send(2'd2, 2'd0, 0, 0, -1, -1, -1);
        idle(3);
        send(2'd2, 2'd0, 0, 0, -1, -1, -1); drain();

        cur_req = "R10";           // early end marker
        send(2'd1, 2'd0, 0, 0, 6, -1, 5);
        idle(2);
        send(2'd1, 2'd0, 0, 0, -1, -1, -1); drain();

        cur_req = "R7";            // reserved indices
        drive(1, 1, 0, 1, 2'd3, 2'd0); idle(2);
        drive(1, 1, 0, 1, 2'd1, 2'd3); idle(2);
        send(2'd0, 2'd0, 0, 0, -1, 5, -1); drain();

        idle(2);
        report();
    end
endmodule